// File: doc/BRIEF.md
# Hardware Return Stack

This block is the processor's private last-in, first-out store. It holds return addresses when subroutines are called and when interrupts are taken. Explicit push and pop instructions can also use it to hold ordinary data words. The storage is a small register array with its own pointer. The core drives a push strobe with a data word, a pop strobe, or a synchronous clear. It reads back the popped word and the live pointer value.

The pointer starts at the highest entry. A push first advances the pointer and then writes at the new position, so the first push after reset wraps round to entry 0. A pop first reads the entry under the pointer and then steps the pointer back. Two sticky flags record an overflow and an underflow. A third flag reports a pop that lost to a push arriving in the same cycle.

Top module: `ret_stack`

## Requirements
- R1: After reset, `sp_o` is 4'hF and `ovf_o`, `unf_o`, `pop_valid_o` and `collide_o` are all 0.
- R2: A cycle with `clr_i` high returns the pointer to 4'hF and clears both sticky flags, the collide flag and `pop_valid_o` on the next cycle. Stored words are kept, and `clr_i` has priority over push and pop.
- R3: A push first increments the pointer and then stores `push_data_i` at the new pointer value. The first push after reset therefore writes entry 0 and leaves `sp_o` at 0 on the next cycle.
- R4: A pop presents the word stored at the current pointer on `pop_data_o` in the following cycle, with `pop_valid_o` high for that one cycle. It also decrements the pointer.
- R5: Words come back in reverse order of pushing, with all 16 bits intact.
- R6: When push and pop are both high in the same cycle, only the push is performed. No pop data is produced, and `collide_o` is high for the next cycle.
- R7: The 4-bit pointer wraps modulo 16: a push at 4'hF gives 4'h0 and a pop at 4'h0 gives 4'hF.
- R8: A push made while 16 unpopped words are already held sets `ovf_o`. The flag stays set until reset or clear.
- R9: A pop made while no unpopped word is held sets `unf_o`. The flag stays set until reset or clear, and the pointer still moves.
- R10: In a cycle with no push, pop or clear, the pointer and flags stay unchanged and `pop_valid_o` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous return to reset state |
| push_i | input | 1 | Push request |
| push_data_i | input | 16 | Word to push |
| pop_i | input | 1 | Pop request |
| pop_data_o | output | 16 | Registered popped word |
| pop_valid_o | output | 1 | Popped word valid this cycle |
| sp_o | output | 4 | Current stack pointer |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| collide_o | output | 1 | Pop was dropped in favour of a push last cycle |

## Verification
A push and a pop can arrive in the same cycle, as when a call is issued while a return retires. The clear can also land on top of either of them. The bench drives push and pop together on purpose. It expects the pointer to advance once, the pushed word to be the next word popped, no popped word to come out, and the collide flag to be raised. A scoreboard queue filled by the driver is compared against every valid pop, so a pop that was wrongly performed shows up as an unexpected or a mismatched word.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_POP   = 2'd2,
        OP_CLEAR = 2'd3
    } stk_op_e;

endpackage

// File: rtl/ret_stack_ctl.sv
module ret_stack_ctl
    import ret_stack_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  stk_op_e          op_i,
    input  logic             lost_pop_i,
    output logic [PTR_W-1:0] sp_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic             ovf_o,
    output logic             unf_o,
    output logic             collide_o
);

    localparam logic [PTR_W-1:0] SP_RESET = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] sp;
        logic [CNT_W-1:0] fill;
        logic             ovf;
        logic             unf;
        logic             collide;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.collide = 1'b0;
        case (op_i)
            OP_CLEAR: begin
                st_d.sp   = SP_RESET;
                st_d.fill = '0;
                st_d.ovf  = 1'b0;
                st_d.unf  = 1'b0;
            end
            OP_PUSH: begin
                st_d.sp      = st_q.sp + 1'b1;
                st_d.collide = lost_pop_i;
                if (st_q.fill == FULL_CNT) begin
                    st_d.ovf = 1'b1;
                end else begin
                    st_d.fill = st_q.fill + 1'b1;
                end
            end
            OP_POP: begin
                st_d.sp = st_q.sp - 1'b1;
                if (st_q.fill == '0) begin
                    st_d.unf = 1'b1;
                end else begin
                    st_d.fill = st_q.fill - 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{sp: SP_RESET, fill: '0, ovf: 1'b0, unf: 1'b0, collide: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sp_o      = st_q.sp;
    assign wr_ptr_o  = st_q.sp + 1'b1;
    assign ovf_o     = st_q.ovf;
    assign unf_o     = st_q.unf;
    assign collide_o = st_q.collide;

endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [PTR_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PTR_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] cell_q [DEPTH];
    logic [DATA_W-1:0] cell_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_comb begin
            cell_d[g] = cell_q[g];
            if (we_i && (waddr_i == PTR_W'(g))) begin
                cell_d[g] = wdata_i;
            end
        end

        always_ff @(posedge clk_i) begin
            cell_q[g] <= cell_d[g];
        end
    end

    assign rdata_o = cell_q[raddr_i];

endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import ret_stack_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     clr_i,
    input  logic                     push_i,
    input  logic [DATA_W-1:0]        push_data_i,
    input  logic                     pop_i,
    output logic [DATA_W-1:0]        pop_data_o,
    output logic                     pop_valid_o,
    output logic [$clog2(DEPTH)-1:0] sp_o,
    output logic                     ovf_o,
    output logic                     unf_o,
    output logic                     collide_o
);

    localparam int unsigned PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } rd_t;

    stk_op_e           op;
    logic              lost_pop;
    logic [PTR_W-1:0]  sp;
    logic [PTR_W-1:0]  wr_ptr;
    logic [DATA_W-1:0] rd_word;
    rd_t               rd_d, rd_q;

    always_comb begin
        if (clr_i) begin
            op = OP_CLEAR;
        end else if (push_i) begin
            op = OP_PUSH;
        end else if (pop_i) begin
            op = OP_POP;
        end else begin
            op = OP_IDLE;
        end
        lost_pop = push_i && pop_i && !clr_i;
    end

    ret_stack_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .op_i       (op),
        .lost_pop_i (lost_pop),
        .sp_o       (sp),
        .wr_ptr_o   (wr_ptr),
        .ovf_o      (ovf_o),
        .unf_o      (unf_o),
        .collide_o  (collide_o)
    );

    ret_stack_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk_i   (clk_i),
        .we_i    (op == OP_PUSH),
        .waddr_i (wr_ptr),
        .wdata_i (push_data_i),
        .raddr_i (sp),
        .rdata_o (rd_word)
    );

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = (op == OP_POP);
        if (op == OP_POP) begin
            rd_d.data = rd_word;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign pop_data_o  = rd_q.data;
    assign pop_valid_o = rd_q.valid;
    assign sp_o        = sp;

endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
    parameter int unsigned PTR_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             clr_i,
    input logic             push_i,
    input logic             pop_i,
    input logic [PTR_W-1:0] sp_o,
    input logic             pop_valid_o,
    input logic             ovf_o,
    input logic             unf_o,
    input logic             collide_o
);

    a_r2_clear_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (sp_o == '1) && !ovf_o && !unf_o && !pop_valid_o && !collide_o);

    a_r3_push_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !clr_i) |=> (sp_o == PTR_W'($past(sp_o) + 1'b1)));

    a_r4_pop_retreats: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !push_i && !clr_i) |=> pop_valid_o && (sp_o == PTR_W'($past(sp_o) - 1'b1)));

    a_r6_push_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && pop_i && !clr_i) |=> collide_o && !pop_valid_o);

    a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !clr_i) |=> ovf_o);

    a_r9_unf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (unf_o && !clr_i) |=> unf_o);

    a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!push_i && !pop_i && !clr_i) |=> $stable(sp_o) && !pop_valid_o && !collide_o);

endmodule

bind ret_stack ret_stack_chk #(.PTR_W($clog2(DEPTH))) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .sp_o        (sp_o),
    .pop_valid_o (pop_valid_o),
    .ovf_o       (ovf_o),
    .unf_o       (unf_o),
    .collide_o   (collide_o)
);

// File: tb/ret_stack_test.sv
`timescale 1ns/1ps
module ret_stack_test;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        clr_i = 1'b0;
    logic        push_i = 1'b0;
    logic [15:0] push_data_i = '0;
    logic        pop_i = 1'b0;
    logic [15:0] pop_data_o;
    logic        pop_valid_o;
    logic [3:0]  sp_o;
    logic        ovf_o, unf_o, collide_o;

    ret_stack uut (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
        .push_i(push_i), .push_data_i(push_data_i), .pop_i(pop_i),
        .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o), .sp_o(sp_o),
        .ovf_o(ovf_o), .unf_o(unf_o), .collide_o(collide_o)
    );

    always #2.5 clk_i = ~clk_i;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [15:0] m_mem [16];
    logic [3:0]  m_sp = 4'hF;
    int          m_fill = 0;
    bit          m_ovf = 0, m_unf = 0;
    logic [15:0] exp_q [$];

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every valid pop is compared with the queue
    always @(negedge clk_i) begin
        if (rst_ni && pop_valid_o) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6 unexpected pop", 32'(pop_data_o), 32'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(pop_data_o == e, "R4/R5 pop data", 32'(pop_data_o), 32'(e));
            end
        end
    end

    always @(posedge clk_i) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check_state(string req, bit exp_coll);
        chk(sp_o == m_sp, req, 32'(sp_o), 32'(m_sp));
        chk(ovf_o == m_ovf, {req, " ovf"}, 32'(ovf_o), 32'(m_ovf));
        chk(unf_o == m_unf, {req, " unf"}, 32'(unf_o), 32'(m_unf));
        chk(collide_o == exp_coll, {req, " collide"}, 32'(collide_o), 32'(exp_coll));
    endtask

    // drive one cycle; called just after a falling edge
    task automatic step(bit pu, bit po, bit cl, logic [15:0] d, string req);
        bit coll;
        bit popped;
        clr_i = cl; push_i = pu; pop_i = po; push_data_i = d;
        coll = 0;
        popped = 0;
        if (cl) begin
            m_sp = 4'hF; m_fill = 0; m_ovf = 0; m_unf = 0;
        end else if (pu) begin
            m_sp = m_sp + 4'd1;
            m_mem[m_sp] = d;
            if (m_fill == 16) m_ovf = 1; else m_fill++;
            coll = po;
        end else if (po) begin
            exp_q.push_back(m_mem[m_sp]);
            popped = 1;
            m_sp = m_sp - 4'd1;
            if (m_fill == 0) m_unf = 1; else m_fill--;
        end
        @(negedge clk_i);
        clr_i = 0; push_i = 0; pop_i = 0;
        check_state(req, coll);
        if (!popped) chk(!pop_valid_o, {req, " no pop_valid"}, 32'(pop_valid_o), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        // R1 reset state
        chk(sp_o == 4'hF, "R1 sp", 32'(sp_o), 32'hF);
        chk(!ovf_o && !unf_o, "R1 flags", {30'h0, ovf_o, unf_o}, 32'h0);
        chk(!pop_valid_o && !collide_o, "R1 valid/collide", {30'h0, pop_valid_o, collide_o}, 32'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R3 first push lands in entry 0
        step(1, 0, 0, 16'hA5C3, "R3 first push");
        chk(sp_o == 4'h0, "R3 sp after first push", 32'(sp_o), 32'h0);
        step(1, 0, 0, 16'h8001, "R3 push");
        step(1, 0, 0, 16'hFFFF, "R3 push");
        // R4/R5 pops in reverse order
        step(0, 1, 0, 16'h0, "R4 pop");
        step(0, 1, 0, 16'h0, "R5 pop");
        // R10 idle
        step(0, 0, 0, 16'h0, "R10 idle");
        step(0, 0, 0, 16'h0, "R10 idle");
        // R6 push and pop together
        step(1, 1, 0, 16'h1234, "R6 collide");
        step(0, 1, 0, 16'h0, "R6 pushed word popped next");
        step(0, 1, 0, 16'h0, "R5 pop oldest");
        // R2 clear then R7 wrap on pop, R9 underflow
        step(0, 0, 1, 16'h0, "R2 clear");
        step(1, 0, 0, 16'h0F0F, "R7 push wraps to 0");
        step(0, 1, 0, 16'h0, "R7 pop 0 to F");
        chk(unf_o == 0, "R9 no underflow yet", 32'(unf_o), 32'h0);
        step(0, 1, 0, 16'h0, "R9 underflow pop");
        chk(unf_o == 1, "R9 unf set", 32'(unf_o), 32'h1);
        step(0, 0, 0, 16'h0, "R9 unf sticky");
        step(0, 0, 1, 16'h0, "R2 clear flags");
        // R7/R8 fill sixteen, then overflow
        for (int i = 0; i < 16; i++) step(1, 0, 0, 16'(16'h3000 + i * 16'h0111), "R7 fill");
        chk(ovf_o == 0, "R8 no ovf at 16", 32'(ovf_o), 32'h0);
        step(1, 0, 0, 16'hBEEF, "R8 overflow push");
        chk(ovf_o == 1, "R8 ovf set", 32'(ovf_o), 32'h1);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 16'h0, "R8 pops after ovf");
        step(1, 0, 1, 16'h7777, "R2 clear beats push");
        step(0, 0, 0, 16'h0, "R10 idle after clear");
        repeat (2) @(negedge clk_i);
        chk(exp_q.size() == 0, "R4 all pops seen", 32'(exp_q.size()), 32'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule